// File: doc/BRIEF.md
# Memory-to-Stream Word Unpacker

This block sits between the read-data channel of a memory-mapped master and a narrow streaming sink. It takes wide data beats, 64 bits by default, and sends each one out as a run of narrow stream words, 16 bits by default. The lowest bits of a beat go out first, then the next lane up. A transfer is started by a request that gives its length as a count of narrow words. So the length only has to be a multiple of the stream width, not of the memory width.

The last beat of a transfer is always accepted whole from the memory side, even when only its lower lanes belong to the transfer. Once the final requested word has gone out, the lanes above it are thrown away and never reach the stream. That final word is marked with the last flag. Reading past the end of a transfer is harmless only for side-effect-free memory, so the block must not be pointed at a FIFO-like peripheral. Both data sides use valid/ready handshakes and accept backpressure at any time. The start address is assumed to be aligned to the memory width. Issuing addresses and handling read errors are done elsewhere.

Top module: `wide_to_narrow_unpacker`

## Requirements
- R1: After reset, reqReady is 1, memReady is 0 and strValid is 0.
- R2: A request with reqWords equal to 0 is dropped: the block stays idle, with reqReady 1 and memReady 0 on the following cycles.
- R3: When a request with reqWords of at least 1 is accepted, memReady is 1 on the next cycle. While a beat still has words to send (strValid is 1), memReady is 0.
- R4: The words of a beat leave in ascending lane order. Word k of a beat is bits [k*STR_W +: STR_W] of memData, so lane 0 is bits [15:0] by default.
- R5: Exactly reqWords stream words are sent per transfer. strLast is 1 on the last of them and 0 on all the others.
- R6: Lanes of the final beat that lie beyond reqWords never appear on the stream. On the cycle after the last word is taken, strValid is 0, memReady is 0 and reqReady is 1.
- R7: A transfer accepts exactly ceil(reqWords / (MEM_W/STR_W)) memory beats. After every lane of a non-final beat has been taken, memReady returns to 1 on the next cycle.
- R8: While strValid is 1 and strReady is 0, strValid, strData and strLast hold their values on the next cycle.
- R9: While a transfer is active and no beat is held, strValid stays 0 for as long as memValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request valid |
| reqReady | output | 1 | Block is idle and can take a request |
| reqWords | input | LEN_W | Transfer length in narrow words |
| memValid | input | 1 | Memory read beat valid |
| memReady | output | 1 | Block can take a memory beat |
| memData | input | MEM_W | Wide read beat |
| strValid | output | 1 | Stream word valid |
| strReady | input | 1 | Sink accepts the stream word |
| strData | output | STR_W | Narrow stream word |
| strLast | output | 1 | Marks the final word of a transfer |

## Verification
The embedded properties run on every cycle. They cover three things: data and last flag staying frozen under stream backpressure, the return to idle right after a flagged word, and memReady rising at the correct moments (after a start and after a beat is used up). They also check that a freshly loaded beat presents its lowest lane first. Some behaviours can only be shown by the bench scenarios, because they need knowledge of the whole transfer: the exact order of every word, the number of words, the position of the last flag, the number of beats fetched and the fact that surplus lanes never appear. These scenarios are run under mixed sink stalls and gaps on the memory side.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  // Strobes sent from the control FSM to the datapath.
  typedef struct packed {
    logic loadBeat;   // capture a new wide beat
    logic shiftOut;   // current narrow word consumed, move to next lane
  } unpkStrobes_t;

endpackage

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
  import unpk_pkg::*;
#(
  parameter int RATIO = 4,
  parameter int LEN_W = 16,
  localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqWords,
  input  logic             memValid,
  output logic             memReady,
  output logic             strValid,
  input  logic             strReady,
  output logic             strLast,
  output unpkStrobes_t     strobes
);

  localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(RATIO - 1);

  logic             active;
  logic             held;
  logic [LEN_W-1:0] remaining;
  logic [IDX_W-1:0] laneIdx;
  logic             emit;
  logic             finalWord;

  assign reqReady  = !active;
  assign memReady  = active && !held;
  assign strValid  = held;
  assign finalWord = (remaining == LEN_W'(1));
  assign strLast   = held && finalWord;
  assign emit      = strValid && strReady;

  assign strobes.loadBeat = memValid && memReady;
  assign strobes.shiftOut = emit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      held      <= 1'b0;
      remaining <= '0;
      laneIdx   <= '0;
    end else if (!active) begin
      if (reqValid && (reqWords != '0)) begin
        active    <= 1'b1;
        remaining <= reqWords;
      end
    end else begin
      if (strobes.loadBeat) begin
        held    <= 1'b1;
        laneIdx <= '0;
      end
      if (emit) begin
        remaining <= remaining - LEN_W'(1);
        laneIdx   <= laneIdx + IDX_W'(1);
        if (finalWord) begin
          // tail lanes of this beat are dropped here
          held   <= 1'b0;
          active <= 1'b0;
        end else if (laneIdx == LAST_LANE) begin
          held <= 1'b0;
        end
      end
    end
  end

  // R2: zero-length request leaves the block idle
  p_zero_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqWords == '0) |=> (reqReady && !memReady));

  // R3: accepted request opens the memory side next cycle
  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqWords != '0) |=> memReady);

  // R7: exhausting a non-final beat re-opens the memory side
  p_refill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (emit && laneIdx == LAST_LANE && !finalWord) |=> (memReady && !strValid));

  // R6: after the flagged word the block is idle
  p_last_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (emit && strLast) |=> (reqReady && !strValid && !memReady));

endmodule

// File: rtl/unpk_datapath.sv
module unpk_datapath
  import unpk_pkg::*;
#(
  parameter int MEM_W = 64,
  parameter int STR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  unpkStrobes_t     strobes,
  input  logic [MEM_W-1:0] memData,
  output logic [STR_W-1:0] strData
);

  generate
    if ((MEM_W % STR_W) != 0 || MEM_W < 2 * STR_W) begin : g_badWidth
      $error("memory width must be a multiple of at least twice the stream width");
    end
  endgenerate

  logic [MEM_W-1:0] beatReg;

  // Lane 0 always sits at the bottom; consuming a word shifts the next lane down.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatReg <= '0;
    end else if (strobes.loadBeat) begin
      beatReg <= memData;
    end else if (strobes.shiftOut) begin
      beatReg <= beatReg >> STR_W;
    end
  end

  assign strData = beatReg[STR_W-1:0];

  // R4: a fresh beat presents its lowest lane first
  p_load_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBeat |=> (strData == $past(memData[STR_W-1:0])));

endmodule

// File: rtl/wide_to_narrow_unpacker.sv
module wide_to_narrow_unpacker
  import unpk_pkg::*;
#(
  parameter int MEM_W = 64,
  parameter int STR_W = 16,
  parameter int LEN_W = 16,
  localparam int RATIO = MEM_W / STR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqWords,
  input  logic             memValid,
  output logic             memReady,
  input  logic [MEM_W-1:0] memData,
  output logic             strValid,
  input  logic             strReady,
  output logic [STR_W-1:0] strData,
  output logic             strLast
);

  unpkStrobes_t strobes;

  unpk_ctrl #(
    .RATIO (RATIO),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWords (reqWords),
    .memValid (memValid),
    .memReady (memReady),
    .strValid (strValid),
    .strReady (strReady),
    .strLast  (strLast),
    .strobes  (strobes)
  );

  unpk_datapath #(
    .MEM_W (MEM_W),
    .STR_W (STR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .memData (memData),
    .strData (strData)
  );

  // R8: stalled output holds word and flag
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strValid && !strReady) |=> (strValid && $stable(strData) && $stable(strLast)));

  // R3: no beat accepted while words of the current one are pending
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strValid && strReady && !strLast) |=> !(memReady && strValid));

endmodule

// File: tb/tb_wide_to_narrow_unpacker.sv
`timescale 1ns/1ps
module tb_wide_to_narrow_unpacker;

  localparam int MEM_W = 64;
  localparam int STR_W = 16;
  localparam int LEN_W = 16;
  localparam int LANES = MEM_W / STR_W;
  localparam int NVEC  = 10;

  // {word count, mode}; mode bit0 = sink stalls, bit1 = memory gaps
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd1, 8'd0}, {8'd4, 8'd0}, {8'd5, 8'd0}, {8'd3, 8'd1}, {8'd8, 8'd1},
    {8'd6, 8'd2}, {8'd7, 8'd3}, {8'd2, 8'd3}, {8'd9, 8'd0}, {8'd12, 8'd3}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [LEN_W-1:0] reqWords = '0;
  logic             memValid = 1'b0;
  logic             memReady;
  logic [MEM_W-1:0] memData = '0;
  logic             strValid;
  logic             strReady = 1'b0;
  logic [STR_W-1:0] strData;
  logic             strLast;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wide_to_narrow_unpacker #(
    .MEM_W (MEM_W),
    .STR_W (STR_W),
    .LEN_W (LEN_W)
  ) dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWords (reqWords),
    .memValid (memValid),
    .memReady (memReady),
    .memData  (memData),
    .strValid (strValid),
    .strReady (strReady),
    .strData  (strData),
    .strLast  (strLast)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [MEM_W-1:0] beatVal(input int v, input int b);
    logic [MEM_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*STR_W +: STR_W] = STR_W'(16'hA000 + v*64 + b*LANES + l);
    return r;
  endfunction

  // Word k of a transfer: lane k%LANES of beat k/LANES (R4)
  function automatic logic [STR_W-1:0] expWord(input int v, input int k);
    return STR_W'(16'hA000 + v*64 + k);
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int beatsSent, wordIdx, cyc, n, mode;
    bit done, prevStall;
    logic [STR_W-1:0] prevData;
    logic prevLast;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", 64'(reqReady), 1);
    check(memReady == 1'b0, "R1", 64'(memReady), 0);
    check(strValid == 1'b0, "R1", 64'(strValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 zero-length request dropped
    reqValid = 1'b1; reqWords = '0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(reqReady == 1'b1, "R2", 64'(reqReady), 1);
      check(memReady == 1'b0, "R2", 64'(memReady), 0);
    end

    // main table
    for (int v = 0; v < NVEC; v++) begin
      n = int'(VEC[v][15:8]);
      mode = int'(VEC[v][7:0]);
      reqValid = 1'b1; reqWords = LEN_W'(n);
      @(negedge clk);
      reqValid = 1'b0;
      check(memReady == 1'b1, "R3", 64'(memReady), 1);
      beatsSent = 0; wordIdx = 0; done = 0; prevStall = 0; prevData = '0; prevLast = 0;
      cyc = 0;
      while (!done && cyc < 500) begin
        memValid = !(mode[1] && (cyc % 3 == 0));
        memData  = beatVal(v, beatsSent);
        strReady = !(mode[0] && (cyc % 2 == 1));
        if (prevStall)
          check(strValid && strData == prevData && strLast == prevLast, "R8",
                64'(strData), 64'(prevData));
        if (strValid)
          check(memReady == 1'b0, "R3", 64'(memReady), 0);
        if (memValid && memReady) beatsSent++;
        if (strValid && strReady) begin
          check(strData == expWord(v, wordIdx), "R4", 64'(strData), 64'(expWord(v, wordIdx)));
          check(strLast == (wordIdx == n - 1), "R5", 64'(strLast), 64'(wordIdx == n - 1));
          if (wordIdx == n - 1) done = 1;
          wordIdx++;
        end
        prevStall = strValid && !strReady;
        prevData = strData;
        prevLast = strLast;
        cyc++;
        @(negedge clk);
      end
      check(done, "R5", 64'(wordIdx), 64'(n));
      // R6 surplus lanes dropped, block idle
      check(!strValid && !memReady && reqReady, "R6",
            64'({strValid, memReady, reqReady}), 64'b001);
      // R7 beat count
      check(beatsSent == (n + LANES - 1) / LANES, "R7", 64'(beatsSent), 64'((n + LANES - 1) / LANES));
      memValid = 1'b0;
      strReady = 1'b0;
      @(negedge clk);
    end

    // R9 memory starved: no stream output
    reqValid = 1'b1; reqWords = LEN_W'(2);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(strValid == 1'b0, "R9", 64'(strValid), 0);
      check(memReady == 1'b1, "R9", 64'(memReady), 1);
    end
    memValid = 1'b1; memData = beatVal(40, 0);
    @(negedge clk);
    memValid = 1'b0; strReady = 1'b1;
    check(strValid && strData == expWord(40, 0) && !strLast, "R9", 64'(strData), 64'(expWord(40, 0)));
    @(negedge clk);
    check(strValid && strData == expWord(40, 1) && strLast, "R5", 64'(strData), 64'(expWord(40, 1)));
    @(negedge clk);
    strReady = 1'b0;
    check(!strValid && reqReady, "R6", 64'(strValid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule